// File: doc/BRIEF.md
# Instruction Fetch Controller

This block fetches one instruction byte from a small synchronous memory each time it is asked to. It holds the program counter, the memory address register, the instruction register and the memory data register. A three-state sequencer sets the load enables of these registers. After a request the sequencer first copies the program counter into the address register. In the next cycle it captures the memory byte at that address into the instruction register. In that same cycle the program counter advances through its own ripple chain of half adders.

The memory answers a read within the same cycle, so the read data is a plain input, valid while the address output is stable. The program counter and address register each have an input multiplexer that can take an external ALU/shifter result. A fetch always selects the local sources. The memory data register load and the memory write strobe stay blocked for the whole fetch, so a caller can rely on a fetch never disturbing data storage.

Top module: `fetch_unit`

## Requirements
- R1: After reset, every load enable and write strobe is 0, both selects are 0, `memAddr` is 0, `instr` is 0 and the program counter holds 0.
- R2: While idle, a `fetchReq` of 0 keeps the block idle: `marEn` and `irEn` stay 0.
- R3: While idle, a `fetchReq` of 1 sampled at a rising edge makes the next cycle the address phase: `marEn`=1, `irEn`=0, `pcEn`=0.
- R4: The address phase is always followed by the data phase: `irEn`=1, `pcEn`=1, `marEn`=0.
- R5: The data phase always returns to idle on the next edge, whatever `fetchReq` is; a request held during the data phase is not stored.
- R6: At the end of the address phase the address register takes the program counter value, and `memAddr` shows it during the data phase.
- R7: At the end of the data phase `instr` takes the byte on `memRdData`, and on the same edge the program counter advances by one.
- R8: The program counter wraps from 255 to 0.
- R9: `mdrEn`, `memWrEn`, `pcSel` and `marSel` are 0 in every cycle. A select value of 0 chooses the local source: the incrementer for the program counter and the program counter for the address register. Values on `aluBus` therefore never reach `memAddr`.
- R10: `marEn` and `irEn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Request to fetch the next instruction |
| aluBus | input | 8 | Alternate ALU/shifter result for the PC and MAR multiplexers |
| memRdData | input | 8 | Memory read data for the address on `memAddr` |
| marEn | output | 1 | Address register load enable |
| irEn | output | 1 | Instruction register load enable |
| pcEn | output | 1 | Program counter load enable |
| mdrEn | output | 1 | Memory data register load enable (blocked) |
| memWrEn | output | 1 | Memory write strobe (blocked) |
| pcSel | output | 1 | Program counter input select, 1 = ALU bus |
| marSel | output | 1 | Address register input select, 1 = ALU bus |
| memAddr | output | 8 | Memory address, the address register contents |
| instr | output | 8 | Instruction register contents |
| mdrData | output | 8 | Memory data register contents |

## Verification
In the data phase the instruction capture and the program counter increment happen on one edge. Each is driven by a different enable, and the increment feeds the address of the next fetch. Back-to-back requests, including one held through the data phase, are used to check this. The bench judges the edge by comparing `instr` with the byte the memory model returned for the current address. The bench then checks that the following fetch puts exactly that address plus one on `memAddr`, including the step from 255 to 0.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_SET_MAR  = 2'b01,
    ST_GET_DATA = 2'b10
  } fetch_state_t;

  typedef struct packed {
    logic marEn;
    logic irEn;
    logic pcEn;
    logic mdrEn;
    logic memWrEn;
    logic pcSel;
    logic marSel;
  } fetch_strobes_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           fetchReq,
  output fetch_strobes_t strobes
);

  fetch_state_t state, stateNext;

  always_comb begin
    unique case (state)
      ST_IDLE:     stateNext = fetchReq ? ST_SET_MAR : ST_IDLE;
      ST_SET_MAR:  stateNext = ST_GET_DATA;
      ST_GET_DATA: stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // Each enable is read straight off one state bit.
  always_comb begin
    strobes.marEn   = state[0];
    strobes.irEn    = state[1];
    strobes.pcEn    = state[1];
    strobes.mdrEn   = 1'b0;
    strobes.memWrEn = 1'b0;
    strobes.pcSel   = 1'b0;
    strobes.marSel  = 1'b0;
  end

endmodule

// File: rtl/fetch_dpath.sv
module fetch_dpath
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetch_strobes_t    strobes,
  input  logic [ADDR_W-1:0] aluBus,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] instr,
  output logic [DATA_W-1:0] mdrData
);

  logic [ADDR_W-1:0] pcReg, marReg, pcInc, pcNext, marNext;
  logic [ADDR_W-1:0] carry;

  // Ripple chain of half adders adding one.
  assign carry[0] = 1'b1;
  for (genvar i = 0; i < ADDR_W; i++) begin : g_halfAdd
    assign pcInc[i] = pcReg[i] ^ carry[i];
    if (i < ADDR_W - 1) begin : g_carry
      assign carry[i+1] = pcReg[i] & carry[i];
    end
  end

  assign pcNext  = strobes.pcSel  ? aluBus : pcInc;
  assign marNext = strobes.marSel ? aluBus : pcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg   <= '0;
      marReg  <= '0;
      instr   <= '0;
      mdrData <= '0;
    end else begin
      if (strobes.pcEn)  pcReg   <= pcNext;
      if (strobes.marEn) marReg  <= marNext;
      if (strobes.irEn)  instr   <= memRdData;
      if (strobes.mdrEn) mdrData <= memRdData;
    end
  end

  assign memAddr = marReg;

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] aluBus,
  input  logic [DATA_W-1:0] memRdData,
  output logic              marEn,
  output logic              irEn,
  output logic              pcEn,
  output logic              mdrEn,
  output logic              memWrEn,
  output logic              pcSel,
  output logic              marSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] instr,
  output logic [DATA_W-1:0] mdrData
);

  fetch_strobes_t strobes;

  fetch_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fetchReq (fetchReq),
    .strobes  (strobes)
  );

  fetch_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .aluBus    (aluBus),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .instr     (instr),
    .mdrData   (mdrData)
  );

  assign marEn   = strobes.marEn;
  assign irEn    = strobes.irEn;
  assign pcEn    = strobes.pcEn;
  assign mdrEn   = strobes.mdrEn;
  assign memWrEn = strobes.memWrEn;
  assign pcSel   = strobes.pcSel;
  assign marSel  = strobes.marSel;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic [DATA_W-1:0] memRdData,
  input logic              marEn,
  input logic              irEn,
  input logic              pcEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] instr
);

  logic idleNow;
  assign idleNow = !marEn && !irEn;

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    idleNow && !fetchReq |=> !marEn && !irEn);

  a_r3_req_starts: assert property (@(posedge clk) disable iff (!rstN)
    idleNow && fetchReq |=> marEn && !irEn && !pcEn);

  a_r4_addr_then_data: assert property (@(posedge clk) disable iff (!rstN)
    marEn |=> irEn && pcEn && !marEn);

  a_r5_data_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    irEn |=> !marEn && !irEn);

  a_r6_mar_stable_in_data: assert property (@(posedge clk) disable iff (!rstN)
    irEn |=> memAddr == $past(memAddr));

  a_r7_ir_capture: assert property (@(posedge clk) disable iff (!rstN)
    irEn |=> instr == $past(memRdData));

  a_r10_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({marEn, irEn}));

endmodule

bind fetch_unit fetch_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchReq  (fetchReq),
  .memRdData (memRdData),
  .marEn     (marEn),
  .irEn      (irEn),
  .pcEn      (pcEn),
  .memAddr   (memAddr),
  .instr     (instr)
);

// File: tb/test_fetch_unit.sv
`timescale 1ns/1ps
module test_fetch_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fetchReq = 1'b0;
  logic [7:0] aluBus = 8'h00;
  logic [7:0] memRdData;
  logic       marEn, irEn, pcEn, mdrEn, memWrEn, pcSel, marSel;
  logic [7:0] memAddr, instr, mdrData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] expPc = 8'h00;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  always_comb memRdData = memByte(memAddr);

  fetch_unit i_fetch_unit (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .aluBus(aluBus),
    .memRdData(memRdData), .marEn(marEn), .irEn(irEn), .pcEn(pcEn),
    .mdrEn(mdrEn), .memWrEn(memWrEn), .pcSel(pcSel), .marSel(marSel),
    .memAddr(memAddr), .instr(instr), .mdrData(mdrData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns after the rising edge.
  task automatic step(input logic req, input logic [7:0] alu);
    @(negedge clk);
    fetchReq = req;
    aluBus   = alu;
    @(posedge clk);
    #1;
  endtask

  // Vector: request, ALU bus value, expected {marEn, irEn} after the edge.
  typedef struct packed {
    logic       req;
    logic [7:0] alu;
    logic [1:0] expEn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hA5, 2'b00},
    '{1'b1, 8'hFF, 2'b10},
    '{1'b0, 8'h3C, 2'b01},
    '{1'b1, 8'h77, 2'b00},
    '{1'b1, 8'h80, 2'b10},
    '{1'b1, 8'h01, 2'b01},
    '{1'b1, 8'hEE, 2'b00},
    '{1'b1, 8'h5A, 2'b10},
    '{1'b0, 8'hC3, 2'b01},
    '{1'b0, 8'h99, 2'b00},
    '{1'b0, 8'h42, 2'b00},
    '{1'b1, 8'h10, 2'b10}
  };

  task automatic fullFetch(input string tag);
    step(1'b1, ~expPc);
    check({tag, " R3 marEn"}, marEn, 1'b1);
    step(1'b1, 8'hF0);
    check({tag, " R6 memAddr"}, memAddr, expPc);
    step(1'b0, 8'h0F);
    check({tag, " R7 instr"}, instr, memByte(expPc));
    expPc = expPc + 8'd1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 enables", {marEn, irEn, pcEn, mdrEn, memWrEn, pcSel, marSel}, 7'b0);
    check("R1 memAddr", memAddr, 8'h00);
    check("R1 instr", instr, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // Table walk: R2, R3, R4, R5, R10, with R9 on every row
    for (int v = 0; v < NV; v++) begin
      step(VECS[v].req, VECS[v].alu);
      check($sformatf("R2/R3/R4/R5 row %0d", v), {marEn, irEn}, VECS[v].expEn);
      check($sformatf("R9 row %0d", v), {mdrEn, memWrEn, pcSel, marSel}, 4'b0);
      if (VECS[v].expEn == 2'b01) begin
        check($sformatf("R4 pcEn row %0d", v), pcEn, 1'b1);
        check($sformatf("R6 addr row %0d", v), memAddr, expPc);
      end
      if (VECS[v].expEn == 2'b00 && v > 0 && VECS[v-1].expEn == 2'b01) begin
        check($sformatf("R7 instr row %0d", v), instr, memByte(expPc));
        expPc = expPc + 8'd1;
      end
    end
    // Row 11 left the block in the address phase; finish that fetch.
    step(1'b0, 8'h00);
    check("R6 addr tail", memAddr, expPc);
    step(1'b0, 8'h00);
    check("R7 instr tail", instr, memByte(expPc));
    expPc = expPc + 8'd1;

    // R2: a long idle stretch with a busy ALU bus leaves everything still
    for (int k = 0; k < 5; k++) step(1'b0, 8'(k * 51));
    check("R2 idle enables", {marEn, irEn}, 2'b00);
    check("R9 memAddr unaffected by aluBus", memAddr, expPc - 8'd1);
    check("R9 mdrData untouched", mdrData, 8'h00);

    // R8: run up to 255, then wrap
    while (expPc != 8'hFF) fullFetch("run");
    fullFetch("R8 at 255");
    check("R8 wrapped pc", expPc, 8'h00);
    fullFetch("R8 after wrap");
    check("R8 second fetch addr", memAddr, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule